// File: doc/BRIEF.md
# Single-Clock FIFO with Same-Edge Status Flags

This block is a first-in first-out buffer in which writer and reader share one clock. Words are written with `wr_en` and read with `rd_en`. Reads are standard mode: a word reaches `rd_data` only in the cycle after an accepted read. A word written into an empty buffer does not move to the output by itself. The buffer holds `2**AW` words of `DW` bits. Because there is only one clock domain, no synchronizers are needed. Every status flag is registered from the next-state occupancy, so it is correct right after the clock edge that carries the operation causing it. There is no added cycle of delay.

The control is a three-state machine over occupancy: `OCC_EMPTY`, `OCC_PART` and `OCC_FULL`. Its transitions are named as follows:
- **fill-start**: `OCC_EMPTY` to `OCC_PART`, on a write into an empty buffer (or to `OCC_FULL` when the depth is one word).
- **drain-last**: `OCC_PART` to `OCC_EMPTY`, on a read that takes the last word.
- **fill-last**: `OCC_PART` to `OCC_FULL`, on a write that takes the last free slot.
- **drain-first**: `OCC_FULL` to `OCC_PART`, on a read alone.

Every other case is a self-loop. A write while full, with no read, is rejected and raises `wr_err`. A read while empty is rejected and raises `rd_err`. A rejected operation changes neither the stored words nor the pointers. The almost-full and almost-empty levels are parameters. The write and read pointers are available at the ports as counts.

Top module: `sfifo_core`

## Requirements
- R1: While `rst_n` is low and after its release, `empty` and `almost_empty` are 1. `full`, `almost_full`, `wr_err`, `rd_err`, `wr_cnt`, `rd_cnt` and `rd_data` are all 0.
- R2: Data leaves in the order it was accepted. After the edge carrying an accepted read, `rd_data` shows the oldest stored word. Otherwise `rd_data` holds its value, including when a word is written into an empty buffer.
- R3: `empty` is 1 exactly when occupancy is 0, and `full` is 1 exactly when occupancy is `2**AW`. Both are updated at the same edge as the write or read that changes occupancy.
- R4: At that same edge, `almost_full` is 1 exactly when occupancy >= `AFULL_LVL`, and `almost_empty` is 1 exactly when occupancy <= `AEMPTY_LVL`.
- R5: A write while `full` is 1 and `rd_en` is 0 is rejected. `wr_err` is 1 for the following cycle, and the stored words, `wr_cnt` and the flags stay unchanged.
- R6: A read while `empty` is 1 is rejected. `rd_err` is 1 for the following cycle, and `rd_cnt` and `rd_data` stay unchanged.
- R7: When empty, a simultaneous read and write accepts the write and rejects the read: `rd_err` is 1, `wr_err` is 0, and `empty` goes to 0.
- R8: When full, a simultaneous read and write accepts both. `full` stays 1 and neither error flag is raised.
- R9: `wr_cnt` and `rd_cnt` are the write and read pointers. Each advances by one, modulo `2**AW`, on each accepted write or read respectively.
- R10: When partly filled, a simultaneous accepted read and write leaves occupancy, and therefore all four level flags, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to write |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Last word read out |
| full | output | 1 | Occupancy equals depth |
| empty | output | 1 | Occupancy is zero |
| almost_full | output | 1 | Occupancy >= AFULL_LVL |
| almost_empty | output | 1 | Occupancy <= AEMPTY_LVL |
| wr_err | output | 1 | Previous cycle had a rejected write |
| rd_err | output | 1 | Previous cycle had a rejected read |
| wr_cnt | output | AW | Write pointer |
| rd_cnt | output | AW | Read pointer |

## Verification
On every cycle, the assertions check the following: rejected operations raise their error flag and keep the pointers and output word, the two boundary cases of simultaneous access behave as specified, the level flags agree with the occupancy, and pointers step by one. Only the bench scenarios can show that the words come out in the order they went in, that a rejected write leaves the stored contents intact, and that every flag follows the exact occupancy through long fill, drain and mixed traffic. These checks are made against a queue-based reference model.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_e;

    typedef enum logic {
        SIDE_WR = 1'b0,
        SIDE_RD = 1'b1
    } side_e;
endpackage

// File: rtl/sfifo_ptr.sv
module sfifo_ptr #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr <= '0;
        else if (step) ptr <= ptr + 1'b1;
    end

    // R9: pointer moves by exactly one per accepted operation, wrapping
    a_r9_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (ptr == $past(ptr) + 1'b1));
    a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(ptr));
endmodule

// File: rtl/sfifo_mem.sv
module sfifo_mem #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata <= '0;
        else if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
    import sfifo_pkg::*;
#(
    parameter int AW         = 4,
    parameter int AFULL_LVL  = 12,
    parameter int AEMPTY_LVL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic rd_en,
    output logic wr_ok,
    output logic rd_ok,
    output logic full,
    output logic empty,
    output logic almost_full,
    output logic almost_empty,
    output logic wr_err,
    output logic rd_err
);
    localparam int DEPTH = 1 << AW;
    localparam int CW    = AW + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] AF_C    = CW'(AFULL_LVL);
    localparam logic [CW-1:0] AE_C    = CW'(AEMPTY_LVL);

    occ_state_e    state_q, state_d;
    logic [CW-1:0] occ_q, occ_d;
    logic          wr_rej, rd_rej;

    // acceptance decode
    always_comb begin
        rd_ok  = rd_en && (state_q != OCC_EMPTY);
        wr_ok  = wr_en && ((state_q != OCC_FULL) || rd_en);
        wr_rej = wr_en && !wr_ok;
        rd_rej = rd_en && !rd_ok;
    end

    // next occupancy and next state
    always_comb begin
        unique case ({wr_ok, rd_ok})
            2'b10:   occ_d = occ_q + 1'b1;
            2'b01:   occ_d = occ_q - 1'b1;
            default: occ_d = occ_q;
        endcase

        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (wr_ok) state_d = (occ_d == DEPTH_C) ? OCC_FULL : OCC_PART;
            end
            OCC_PART: begin
                if (occ_d == '0)          state_d = OCC_EMPTY;
                else if (occ_d == DEPTH_C) state_d = OCC_FULL;
            end
            OCC_FULL: begin
                if (occ_d != DEPTH_C) state_d = (occ_d == '0) ? OCC_EMPTY : OCC_PART;
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            occ_q   <= '0;
        end else begin
            state_q <= state_d;
            occ_q   <= occ_d;
        end
    end

    // output register: flags from next-state values, no added latency
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full         <= 1'b0;
            empty        <= 1'b1;
            almost_full  <= 1'b0;
            almost_empty <= 1'b1;
            wr_err       <= 1'b0;
            rd_err       <= 1'b0;
        end else begin
            full         <= (state_d == OCC_FULL);
            empty        <= (state_d == OCC_EMPTY);
            almost_full  <= (occ_d >= AF_C);
            almost_empty <= (occ_d <= AE_C);
            wr_err       <= wr_rej;
            rd_err       <= rd_rej;
        end
    end

    // R3: the two end flags never coexist and match the occupancy
    a_r3_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    a_r3_empty_occ: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (occ_q == '0));
    a_r3_full_occ: assert property (@(posedge clk) disable iff (!rst_n)
        full == (occ_q == DEPTH_C));
    // R4: warning flags agree with the occupancy at every cycle
    a_r4_af_occ: assert property (@(posedge clk) disable iff (!rst_n)
        almost_full == (occ_q >= AF_C));
    a_r4_ae_occ: assert property (@(posedge clk) disable iff (!rst_n)
        almost_empty == (occ_q <= AE_C));
    // R5: write while full with no read is refused and flagged
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> (wr_err && full && $stable(occ_q)));
    // R7: empty with both requests
    a_r7_empty_both: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && wr_en && rd_en) |=> (rd_err && !wr_err && !empty));
    // R8: full with both requests
    a_r8_full_both: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && rd_en) |=> (full && !wr_err && !rd_err));
    // R10: both accepted leaves occupancy where it was
    a_r10_occ_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && rd_ok) |=> $stable(occ_q));
endmodule

// File: rtl/sfifo_core.sv
module sfifo_core
    import sfifo_pkg::*;
#(
    parameter int DW         = 8,
    parameter int AW         = 4,
    parameter int AFULL_LVL  = 12,
    parameter int AEMPTY_LVL = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          full,
    output logic          empty,
    output logic          almost_full,
    output logic          almost_empty,
    output logic          wr_err,
    output logic          rd_err,
    output logic [AW-1:0] wr_cnt,
    output logic [AW-1:0] rd_cnt
);
    localparam int NSIDE = 2;

    logic          wr_ok, rd_ok;
    logic [1:0]    side_step;
    logic [AW-1:0] side_ptr [NSIDE];

    sfifo_ctrl #(
        .AW(AW), .AFULL_LVL(AFULL_LVL), .AEMPTY_LVL(AEMPTY_LVL)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .wr_ok(wr_ok), .rd_ok(rd_ok), .full(full), .empty(empty),
        .almost_full(almost_full), .almost_empty(almost_empty),
        .wr_err(wr_err), .rd_err(rd_err)
    );

    assign side_step[SIDE_WR] = wr_ok;
    assign side_step[SIDE_RD] = rd_ok;

    for (genvar g = 0; g < NSIDE; g++) begin : g_ptr
        sfifo_ptr #(.AW(AW)) u_ptr (
            .clk(clk), .rst_n(rst_n), .step(side_step[g]), .ptr(side_ptr[g])
        );
    end

    assign wr_cnt = side_ptr[SIDE_WR];
    assign rd_cnt = side_ptr[SIDE_RD];

    sfifo_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .we(wr_ok), .waddr(wr_cnt), .wdata(wr_data),
        .re(rd_ok), .raddr(rd_cnt), .rdata(rd_data)
    );

    // R2: no accepted read, no change at the output (no fall-through)
    a_r2_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || empty) |=> $stable(rd_data));
    // R6: read while empty is flagged and moves nothing
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> (rd_err && $stable(rd_cnt) && $stable(rd_data)));
    // R5: refused write leaves the write pointer in place
    a_r5_wptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> $stable(wr_cnt));
endmodule

// File: tb/sfifo_core_bench.sv
`timescale 1ns/100ps
module sfifo_core_bench;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;
    localparam int AFL = 12;
    localparam int AEL = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic full, empty, almost_full, almost_empty, wr_err, rd_err;
    logic [AW-1:0] wr_cnt, rd_cnt;

    always #2.5 clk = ~clk;

    sfifo_core #(.DW(DW), .AW(AW), .AFULL_LVL(AFL), .AEMPTY_LVL(AEL)) u_sfifo_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty),
        .almost_full(almost_full), .almost_empty(almost_empty),
        .wr_err(wr_err), .rd_err(rd_err), .wr_cnt(wr_cnt), .rd_cnt(rd_cnt)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    bit mon_on = 1'b0;

    // reference model
    logic [DW-1:0] exp_q [$];
    int occ = 0;
    int exp_wcnt = 0;
    int exp_rcnt = 0;
    bit exp_werr = 1'b0;
    bit exp_rerr = 1'b0;
    bit exp_rd_ok = 1'b0;
    logic [DW-1:0] last_rd = '0;

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // driver: applies one cycle of stimulus and pushes expected words
    task automatic drive(input bit we, input logic [DW-1:0] wd, input bit re);
        bit rok, wok;
        @(negedge clk);
        wr_en = we;
        wr_data = wd;
        rd_en = re;
        rok = re && (occ > 0);
        wok = we && ((occ < DEPTH) || re);
        exp_werr = we && !wok;
        exp_rerr = re && !rok;
        exp_rd_ok = rok;
        if (wok) begin
            exp_q.push_back(wd);
            exp_wcnt = (exp_wcnt + 1) % DEPTH;
            occ++;
        end
        if (rok) begin
            exp_rcnt = (exp_rcnt + 1) % DEPTH;
            occ--;
        end
    endtask

    // monitor: pops expected words and compares every result after each edge
    always @(posedge clk) begin
        if (mon_on) begin
            #1;
            if (exp_rd_ok) last_rd = exp_q.pop_front();
            chk("R2 rd_data", rd_data, last_rd);
            chk("R3 empty", empty, occ == 0);
            chk("R3 full", full, occ == DEPTH);
            chk("R4 almost_full", almost_full, occ >= AFL);
            chk("R4 almost_empty", almost_empty, occ <= AEL);
            chk("R5 wr_err", wr_err, exp_werr);
            chk("R6 rd_err", rd_err, exp_rerr);
            chk("R9 wr_cnt", wr_cnt, exp_wcnt);
            chk("R9 rd_cnt", rd_cnt, exp_rcnt);
        end
    end

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 empty", empty, 1);
        chk("R1 almost_empty", almost_empty, 1);
        chk("R1 full", full, 0);
        chk("R1 almost_full", almost_full, 0);
        chk("R1 errs", {wr_err, rd_err}, 0);
        chk("R1 counts", {wr_cnt, rd_cnt}, 0);
        chk("R1 rd_data", rd_data, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R6: read while empty
        drive(0, 8'h00, 1);
        // R2: write into empty does not change output
        drive(1, 8'hA5, 0);
        drive(0, 8'h00, 0);
        @(posedge clk); #2;
        chk("R2 no fall-through", rd_data, 0);
        // fill to full (R3, R4)
        for (int i = 1; i < DEPTH; i++) drive(1, DW'(8'h10 + i), 0);
        drive(0, 8'h00, 0);
        @(posedge clk); #2;
        chk("R3 full after last write", full, 1);
        // R5: write while full rejected, contents kept
        drive(1, 8'hEE, 0);
        @(posedge clk); #2;
        chk("R5 wr_err pulse", wr_err, 1);
        drive(0, 8'h00, 0);
        @(posedge clk); #2;
        chk("R5 wr_err clears", wr_err, 0);
        // R8: full with both
        drive(1, 8'h77, 1);
        @(posedge clk); #2;
        chk("R8 stays full", {full, wr_err, rd_err}, 3'b100);
        // drain fully (R2 ordering, R3 empty)
        for (int i = 0; i < DEPTH; i++) drive(0, 8'h00, 1);
        drive(0, 8'h00, 0);
        @(posedge clk); #2;
        chk("R3 empty after drain", empty, 1);
        // R7: empty with both
        drive(1, 8'h5C, 1);
        @(posedge clk); #2;
        chk("R7 read refused", {rd_err, wr_err, empty}, 3'b100);
        // R10: partial with both
        for (int i = 0; i < 4; i++) drive(1, DW'(8'h30 + i), 0);
        drive(1, 8'h40, 1);
        @(posedge clk); #2;
        chk("R10 occupancy kept", {almost_empty, almost_full, empty, full}, 4'b0000);
        drive(1, 8'h41, 1);
        drive(0, 8'h00, 0);
        // mixed traffic with biased phases
        lfsr = 16'hACE1;
        for (int i = 0; i < 1200; i++) begin
            bit we, re;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if ((i / 150) % 2 == 0) begin
                we = lfsr[0] | lfsr[1];
                re = lfsr[2] & lfsr[3];
            end else begin
                we = lfsr[0] & lfsr[1];
                re = lfsr[2] | lfsr[3];
            end
            drive(we, lfsr[15:8], re);
        end
        drive(0, 8'h00, 0);
        @(posedge clk); #2;
        mon_on = 1'b0;
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule